// File: doc/BRIEF.md
# Block-Skip Carry Adder

This block adds two unsigned W-bit operands and an incoming carry, producing a W-bit sum and a carry-out. It is purely combinational. The operand bits are grouped into equal slices of R bits. Inside each slice, a chain of full adders ripples the carry from the least significant bit upward.

For each slice, a group-propagate signal is formed by ANDing together every per-bit propagate of that slice. A per-bit propagate is true when the two operand bits differ. When the group-propagate is true, the slice's carry-out is taken straight from its carry-in, so the carry skips past the ripple chain. Otherwise the slice's carry-out is the carry leaving its top full adder. Each slice's carry-out becomes the carry-in of the next slice.

The sum bits always come from the ripple chain, and that chain is fed the true slice carry-in. The sum is therefore correct whichever path the carry-out takes. The block can serve as the carry-in-zero adder inside a carry-select structure, or it can stand alone as a general adder. W must be a whole multiple of R; any other setting stops elaboration.

Top module: `csk_adder`

## Requirements
- R1: For every pair of operands and every carry-in, {co, sum} equals opa + opb + ci, taken as an unsigned (W+1)-bit value.
- R2: A slice's group-propagate is true exactly when, at every bit of that slice, opa differs from opb.
- R3: When a slice's group-propagate is true, its carry-out equals its carry-in. With opa = ~opb, the carry from ci therefore reaches co, giving sum of all zeros and co = 1 when ci = 1.
- R4: When a slice's group-propagate is false, its carry-out equals the carry leaving the slice's most significant full adder.
- R5: Slice 0 receives ci. Slice k+1 receives the carry-out of slice k. co is the carry-out of the last slice, so a carry raised in a low slice must reach higher slices.
- R6: A bit where both operands are 1 generates a carry into the next bit. A bit where both operands are 0 passes no carry onward: opa = opb = 0 with ci = 1 gives sum = 1 and co = 0.
- R7: With opa = ~opb and ci = 0, the sum is all ones and co = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | W | First operand |
| opb | input | W | Second operand |
| ci | input | 1 | Incoming carry |
| sum | output | W | Sum bits |
| co | output | 1 | Outgoing carry |

## Verification
The immediate checks assume that opa, opb and ci are two-valued and held steady long enough for the carry network to settle. They compare each skip decision against the rippled carry that it stands in for. The stimulus applies each operand set and waits a fixed delay before sampling, so every observation sees settled values. The patterns include fully propagating operands, fully killing operands, generating operands and long carry chains. Together these force every slice's skip multiplexer to select each of its two inputs.

// File: rtl/csk_pkg.sv
// Package: shared defaults and helpers for the block-skip carry adder.
// Assumes: widths are positive; the slice width divides the adder width.
package csk_pkg;
    localparam int unsigned CSK_W_DEF = 16;
    localparam int unsigned CSK_R_DEF = 4;

    // Number of slices for a given adder width and slice width.
    function automatic int unsigned csk_slices(input int unsigned w, input int unsigned r);
        return w / r;
    endfunction
endpackage

// File: rtl/csk_fa.sv
// Module: one-bit full adder that also exposes its propagate term.
// Assumes: inputs are two-valued.
module csk_fa (
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic s,
    output logic co,
    output logic p
);
    // Sum, carry and propagate for a single bit position.
    always_comb begin
        p  = a ^ b;
        s  = p ^ ci;
        co = (a & b) | (p & ci);
    end
endmodule

// File: rtl/csk_slice.sv
// Module: one R-bit slice with a rippled carry chain and a skip multiplexer
// on its carry-out, selected by the AND of all per-bit propagates.
// Assumes: R >= 1; sum bits are always taken from the ripple chain.
module csk_slice #(
    parameter int unsigned R = 4
) (
    input  logic [R-1:0] a,
    input  logic [R-1:0] b,
    input  logic         ci,
    output logic [R-1:0] s,
    output logic         co,
    output logic         grp_p
);
    logic [R:0]   rip;
    logic [R-1:0] bit_p;

    assign rip[0] = ci;

    genvar i;
    generate
        for (i = 0; i < R; i++) begin : g_bit
            csk_fa u_fa (
                .a  (a[i]),
                .b  (b[i]),
                .ci (rip[i]),
                .s  (s[i]),
                .co (rip[i+1]),
                .p  (bit_p[i])
            );
        end
    endgenerate

    // Group propagate and skip selection of the slice carry-out.
    always_comb begin
        grp_p = &bit_p;
        co    = grp_p ? ci : rip[R];
    end

    // Guard: a skipped carry must agree with the rippled one (R3).
    always_comb begin
        if (grp_p) begin
            p_skip_agrees_r3 : assert (rip[R] == ci)
                else $error("slice skip carry differs from rippled carry");
        end
    end

    // Guard: group propagate only when every bit of the slice differs (R2).
    always_comb begin
        p_grp_needs_diff_r2 : assert (grp_p == ((a ^ b) == {R{1'b1}}))
            else $error("group propagate inconsistent with operand bits");
    end

    // Guard: all-kill slice passes no carry onward (R6).
    always_comb begin
        if ((a | b) == '0) begin
            p_kill_blocks_r6 : assert (co == 1'b0)
                else $error("carry escaped a slice with all bits zero");
        end
    end
endmodule

// File: rtl/csk_adder.sv
// Module: W-bit block-skip carry adder built from W/R chained slices.
// Assumes: W is a multiple of R (checked at elaboration); fully combinational.
module csk_adder #(
    parameter int unsigned W = csk_pkg::CSK_W_DEF,
    parameter int unsigned R = csk_pkg::CSK_R_DEF
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         ci,
    output logic [W-1:0] sum,
    output logic         co
);
    localparam int unsigned NS = csk_pkg::csk_slices(W, R);

    logic [NS:0]   chain;
    logic [NS-1:0] grp;

    generate
        if ((W % R) != 0 || R == 0) begin : g_bad_cfg
            $error("csk_adder: W must be a nonzero multiple of R");
        end
    endgenerate

    assign chain[0] = ci;

    genvar k;
    generate
        for (k = 0; k < NS; k++) begin : g_slice
            csk_slice #(.R(R)) u_slice (
                .a     (opa[k*R +: R]),
                .b     (opb[k*R +: R]),
                .ci    (chain[k]),
                .s     (sum[k*R +: R]),
                .co    (chain[k+1]),
                .grp_p (grp[k])
            );
        end
    endgenerate

    // Final carry is the last slice's carry-out (R5).
    always_comb begin
        co = chain[NS];
    end

    // Guard: overall result matches the arithmetic sum (R1).
    always_comb begin
        p_sum_exact_r1 : assert ({co, sum} == ({1'b0, opa} + {1'b0, opb} + {{W{1'b0}}, ci}))
            else $error("adder result differs from arithmetic sum");
    end

    // Guard: with every slice propagating, carry-in reaches the output (R3).
    always_comb begin
        if (&grp) begin
            p_full_skip_r3 : assert (co == ci)
                else $error("full-skip carry-out differs from carry-in");
        end
    end
endmodule

// File: tb/csk_adder_bench.sv
// Bench: table-driven and directed checks of the block-skip carry adder.
module csk_adder_bench;
    localparam int  W        = 16;
    localparam int  R        = 4;
    localparam time CLK_PER  = 10ns;
    localparam int  WATCHDOG = 20000;
    localparam int  NVEC     = 12;

    // Vector layout: {ci, opa, opb, exp_co, exp_sum}
    localparam logic [49:0] VEC [NVEC] = '{
        {1'b0, 16'h0000, 16'h0000, 1'b0, 16'h0000},
        {1'b1, 16'h0000, 16'h0000, 1'b0, 16'h0001},
        {1'b0, 16'hFFFF, 16'h0001, 1'b1, 16'h0000},
        {1'b1, 16'hA5A5, 16'h5A5A, 1'b1, 16'h0000},
        {1'b0, 16'hA5A5, 16'h5A5A, 1'b0, 16'hFFFF},
        {1'b0, 16'h1234, 16'h4321, 1'b0, 16'h5555},
        {1'b0, 16'h8000, 16'h8000, 1'b1, 16'h0000},
        {1'b1, 16'h00F0, 16'h000F, 1'b0, 16'h0100},
        {1'b0, 16'h0FFF, 16'h0001, 1'b0, 16'h1000},
        {1'b1, 16'hFFFF, 16'hFFFF, 1'b1, 16'hFFFF},
        {1'b0, 16'h7FFF, 16'h7FFF, 1'b0, 16'hFFFE},
        {1'b1, 16'hF00F, 16'h0FF0, 1'b1, 16'h0000}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic         ci = 1'b0;
    logic [W-1:0] sum;
    logic         co;
    int           n_chk = 0;
    int           n_fail = 0;
    int           cyc = 0;

    csk_adder #(.W(W), .R(R)) u_csk_adder (
        .opa (opa),
        .opb (opb),
        .ci  (ci),
        .sum (sum),
        .co  (co)
    );

    // Free-running clock for reset and watchdog timing.
    always #(CLK_PER/2) clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog expired after %0d cycles", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Apply operands, let them settle, and compare against expected values.
    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic c,
                         input logic [W:0] exp, input string req);
        opa = a;
        opb = b;
        ci  = c;
        #(CLK_PER/4);
        n_chk = n_chk + 1;
        if ({co, sum} !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s a=%h b=%h ci=%b actual=%h expected=%h", req, a, b, c, {co, sum}, exp);
        end
        #(CLK_PER/4);
    endtask

    initial begin
        logic [W-1:0] lfsr_a = 16'hACE1;
        logic [W-1:0] lfsr_b = 16'h1D2B;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Idle state: zero operands give zero result (R1)
        apply('0, '0, 1'b0, '0, "R1 idle");

        // Table walk (R1, R3, R5, R6, R7)
        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][48:33], VEC[i][32:17], VEC[i][49], VEC[i][16:0], "R1 table");
        end

        // Full skip path end to end: opa = ~opb (R3, R7)
        apply(16'h3C96, 16'hC369, 1'b1, {1'b1, 16'h0000}, "R3 full skip ci=1");
        apply(16'h3C96, 16'hC369, 1'b0, {1'b0, 16'hFFFF}, "R7 full propagate ci=0");

        // Group propagate false by a single equal bit stops skipping (R2, R4)
        apply(16'h000E, 16'h0000, 1'b1, {1'b0, 16'h000F}, "R2 partial propagate");
        apply(16'h000F, 16'h0001, 1'b0, {1'b0, 16'h0010}, "R4 ripple carry-out");

        // Generate in low slice travels through skipping upper slices (R5)
        apply(16'hFFF8, 16'h0008, 1'b0, {1'b1, 16'h0000}, "R5 generated carry chains");
        apply(16'h0F08, 16'h0008, 1'b0, {1'b0, 16'h0F10}, "R5 carry into next slice");

        // Kill slice stops an incoming carry (R6)
        apply(16'h000F, 16'h0001, 1'b1, {1'b0, 16'h0011}, "R6 generate");
        apply(16'h0000, 16'h0000, 1'b1, {1'b0, 16'h0001}, "R6 kill");

        // Pseudo-random sweep against arithmetic sum (R1)
        for (int j = 0; j < 300; j++) begin
            lfsr_a = {lfsr_a[14:0], lfsr_a[15] ^ lfsr_a[13] ^ lfsr_a[12] ^ lfsr_a[10]};
            lfsr_b = {lfsr_b[14:0], lfsr_b[15] ^ lfsr_b[14] ^ lfsr_b[12] ^ lfsr_b[3]};
            apply(lfsr_a, lfsr_b, lfsr_a[0] ^ lfsr_b[5],
                  {1'b0, lfsr_a} + {1'b0, lfsr_b} + {{W{1'b0}}, lfsr_a[0] ^ lfsr_b[5]},
                  "R1 sweep");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule